// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block is a memory-mapped performance monitor placed beside a DDR memory controller. It holds sixteen 32-bit general counters and one 56-bit free-running cycle counter. Each general counter watches one line of a 64-wide bus of single-cycle event pulses. The line is chosen by an 8-bit slot in a packed event-select word, and that slot also carries the counter's own enable.

Software drives the bank through a plain 32-bit register port with a write strobe and a combinational read. One control register starts, stops and clears counting. A test-select register paired with a preload register lets software load any general counter with an arbitrary value, for example to bring a counter close to wrap. When a counter wraps it raises a one-cycle overflow pulse on its own output bit. A separate interrupt block collects these pulses.

Top module: `evcnt_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters, the cycle counter, the event-select words and the test-select register read 0, counting is stopped and every overflow output is 0.
- R2: A write to the control register at 0xC00 with bit 0 set starts counting and with bit 1 set stops it. If both bits are set in one write, counting stops. Bits written as 0 have no effect. The state register at 0xC04 returns the running state in bit 0.
- R3: Event-select word k sits at 0xC68 + 4·k and covers counters 4k to 4k+3. Counter n uses byte slot 8·(n mod 4) of word n/4. Slot bit 7 enables the counter and slot bits 5:0 give the event number. On each clock edge where counting is running, the slot is enabled and the selected event line is 1, the counter increments by one.
- R4: General counter n reads at offset 0xC78 + 4·n.
- R5: A counter that increments from 0xFFFFFFFF becomes 0. Its overflow output bit is 1 for exactly the one cycle in which the counter reads 0 after the wrap.
- R6: The 56-bit cycle counter increments on every clock edge while counting is running and holds while it is stopped. Bits 55:32 read at 0xC10 in bits 23:0, and bits 31:0 read at 0xC14.
- R7: A control write with bit 2 set clears all general counters and the cycle counter to 0. The event-select words and the running state are left unchanged.
- R8: When the test-select register at 0xC08 holds 19 + n (n from 0 to 15), a write to the preload register at 0xC0C loads counter n with the written value. Any other test-select value makes the preload write have no effect. The test-select register reads back its value.
- R9: A preload that hits a counter on the same edge as that counter's counted event loads the preload value, and the event is dropped.
- R10: Reads of unmapped offsets return 0, and writes to them change no register. The control register and the preload register also read as 0.
- R11: Clearing a counter's slot enable freezes that counter alone. The other enabled counters keep counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| events | input | 64 | Single-cycle event pulses, one per event number |
| ovf | output | 16 | One-cycle wrap pulse per general counter |

## Verification
On every cycle the assertions check the control semantics: a stop bit always leaves counting stopped, and the cycle counter either holds or steps by exactly one, depending on the running state. They also check that a clear empties every counter, that a hitting preload lands exactly the written value, and that an overflow pulse coincides with a counter that has just come from all ones to zero. Other behaviours need a stimulus story, and only the bench scenarios can show them. These are the slot layout and event routing under chosen patterns, a disabled slot ignoring a live event, unmapped writes leaving every register intact, and out-of-range test-select values. The same holds for long random traffic against a behavioural reference model that is compared on every clock.

// File: rtl/evcnt_pkg.sv
// Package: register offsets and field positions shared by the counter bank,
// its checker and anything that decodes the register port.
package evcnt_pkg;
    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFF_CTRL   = 12'hC00;
    localparam logic [REG_AW-1:0] OFF_STATE  = 12'hC04;
    localparam logic [REG_AW-1:0] OFF_TSEL   = 12'hC08;
    localparam logic [REG_AW-1:0] OFF_PRE    = 12'hC0C;
    localparam logic [REG_AW-1:0] OFF_CYC_HI = 12'hC10;
    localparam logic [REG_AW-1:0] OFF_CYC_LO = 12'hC14;
    localparam logic [REG_AW-1:0] OFF_SEL0   = 12'hC68;
    localparam logic [REG_AW-1:0] OFF_CNT0   = 12'hC78;

    localparam int CTRL_START = 0;
    localparam int CTRL_STOP  = 1;
    localparam int CTRL_CLEAR = 2;

    localparam int TSEL_BASE      = 19;
    localparam int SLOT_W         = 8;
    localparam int SLOT_EN_BIT    = 7;
    localparam int SLOTS_PER_WORD = 4;
endpackage

// File: rtl/evcnt_regs.sv
// Module: evcnt_regs
// Holds the software-visible control state: the running flag, the packed
// event-select words and the test-select register. It decodes per-counter
// slot enables, event numbers and preload strobes.
// Assumes word-aligned byte offsets and a 32-bit data word.
module evcnt_regs
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int DW      = 32,
    parameter int EVT_W   = 6,
    localparam int NSW    = (NUM_CNT + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               addr,
    input  logic [DW-1:0]                   wdata,
    output logic                            run,
    output logic                            clr,
    output logic [NUM_CNT-1:0]              slot_en,
    output logic [NUM_CNT-1:0][EVT_W-1:0]   slot_evt,
    output logic [NUM_CNT-1:0]              load,
    output logic [NSW-1:0][DW-1:0]          sel_words,
    output logic [DW-1:0]                   tsel
);
    logic wr_ctrl;
    logic wr_pre;

    // Write strobes for the control and preload registers.
    assign wr_ctrl = wr_en && (addr == OFF_CTRL);
    assign wr_pre  = wr_en && (addr == OFF_PRE);
    assign clr     = wr_ctrl && wdata[CTRL_CLEAR];

    // Running flag: a stop bit overrides a start bit in the same write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr_ctrl) begin
            if (wdata[CTRL_STOP]) begin
                run <= 1'b0;
            end else if (wdata[CTRL_START]) begin
                run <= 1'b1;
            end
        end
    end

    // Test-select register, which routes preload writes to one counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsel <= '0;
        end else if (wr_en && (addr == OFF_TSEL)) begin
            tsel <= wdata;
        end
    end

    // Packed event-select words, four slots each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_words <= '0;
        end else begin
            for (int w = 0; w < NSW; w++) begin
                if (wr_en && (addr == OFF_SEL0 + REG_AW'(4 * w))) begin
                    sel_words[w] <= wdata;
                end
            end
        end
    end

    // Per-counter slot decode and preload strobe.
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
        localparam int WI = n / SLOTS_PER_WORD;
        localparam int LO = SLOT_W * (n % SLOTS_PER_WORD);
        assign slot_en[n]  = sel_words[WI][LO + SLOT_EN_BIT];
        assign slot_evt[n] = sel_words[WI][LO +: EVT_W];
        assign load[n]     = wr_pre && (tsel == DW'(TSEL_BASE + n));
    end
endmodule

// File: rtl/evcnt_counter.sv
// Module: evcnt_counter
// One general event counter. Priority on each edge: preload, then clear,
// then a counted event. It emits a one-cycle wrap pulse when it steps
// from all ones to zero. Assumes the event bus is 2**EVT_W wide.
module evcnt_counter #(
    parameter int CNT_W = 32,
    parameter int EVT_W = 6,
    localparam int NUM_EVT = 2 ** EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               en,
    input  logic [EVT_W-1:0]   evt_sel,
    input  logic [NUM_EVT-1:0] events,
    input  logic               clr,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf
);
    logic hit;

    // A counted event needs the global run state, the slot enable and the chosen line.
    assign hit = run && en && events[evt_sel];

    // Count register with load/clear priority and a registered wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (clr) begin
                cnt <= '0;
            end else if (hit) begin
                cnt <= cnt + 1'b1;
                ovf <= &cnt;
            end
        end
    end
endmodule

// File: rtl/evcnt_cycle.sv
// Module: evcnt_cycle
// Free-running cycle counter. It steps every clock while counting runs and
// is cleared by the global clear. It wraps silently at its full width.
module evcnt_cycle #(
    parameter int CYC_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    output logic [CYC_W-1:0] cyc
);
    // Cycle count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (clr) begin
            cyc <= '0;
        end else if (run) begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/evcnt_bank.sv
// Module: evcnt_bank (top)
// Event counter bank for a memory controller. It holds sixteen general
// counters, one cycle counter and a combinational register read port.
// Assumes CNT_W <= DW < CYC_W <= 2*DW and word-aligned offsets.
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 32,
    parameter int CYC_W   = 56,
    parameter int EVT_W   = 6,
    parameter int DW      = 32,
    localparam int NUM_EVT = 2 ** EVT_W,
    localparam int NSW     = (NUM_CNT + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD,
    localparam int CYC_HW  = CYC_W - DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NUM_EVT-1:0] events,
    output logic [NUM_CNT-1:0] ovf
);
    logic                          run;
    logic                          clr;
    logic [NUM_CNT-1:0]            slot_en;
    logic [NUM_CNT-1:0][EVT_W-1:0] slot_evt;
    logic [NUM_CNT-1:0]            load;
    logic [NSW-1:0][DW-1:0]        sel_words;
    logic [DW-1:0]                 tsel;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;
    logic [CYC_W-1:0]              cyc;

    evcnt_regs #(
        .NUM_CNT (NUM_CNT),
        .DW      (DW),
        .EVT_W   (EVT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .run       (run),
        .clr       (clr),
        .slot_en   (slot_en),
        .slot_evt  (slot_evt),
        .load      (load),
        .sel_words (sel_words),
        .tsel      (tsel)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evcnt_counter #(
            .CNT_W (CNT_W),
            .EVT_W (EVT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .en       (slot_en[n]),
            .evt_sel  (slot_evt[n]),
            .events   (events),
            .clr      (clr),
            .load     (load[n]),
            .load_val (wdata[CNT_W-1:0]),
            .cnt      (cnt_bus[n]),
            .ovf      (ovf[n])
        );
    end

    evcnt_cycle #(
        .CYC_W (CYC_W)
    ) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (clr),
        .cyc   (cyc)
    );

    // Read multiplexer: unmapped and write-only offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == OFF_STATE)  rdata[0] = run;
        if (addr == OFF_TSEL)   rdata = tsel;
        if (addr == OFF_CYC_HI) rdata[CYC_HW-1:0] = cyc[CYC_W-1:DW];
        if (addr == OFF_CYC_LO) rdata = cyc[DW-1:0];
        for (int w = 0; w < NSW; w++) begin
            if (addr == OFF_SEL0 + REG_AW'(4 * w)) rdata = sel_words[w];
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if (addr == OFF_CNT0 + REG_AW'(4 * n)) rdata[CNT_W-1:0] = cnt_bus[n];
        end
    end
endmodule

// File: rtl/evcnt_checker.sv
// Module: evcnt_checker
// Cycle-level properties of the counter bank, attached by bind. It observes
// the register port, the running flag, test-select and all count values.
module evcnt_checker
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 32,
    parameter int CYC_W   = 56,
    parameter int DW      = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [REG_AW-1:0]               addr,
    input logic [DW-1:0]                   wdata,
    input logic                            run,
    input logic [DW-1:0]                   tsel,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_bus,
    input logic [CYC_W-1:0]                cyc,
    input logic [NUM_CNT-1:0]              ovf
);
    logic ctrl_w;
    logic clr_w;
    assign ctrl_w = wr_en && (addr == OFF_CTRL);
    assign clr_w  = ctrl_w && wdata[CTRL_CLEAR];

    assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && wdata[CTRL_STOP]) |=> !run);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && wdata[CTRL_START] && !wdata[CTRL_STOP]) |=> run);

    assert_cyc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_w) |=> $stable(cyc));

    assert_cyc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr_w) |=> (cyc == CYC_W'($past(cyc) + 1'b1)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ((cyc == '0) && (cnt_bus == '0)));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
        assert_ovf_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[n] |-> ((cnt_bus[n] == '0) && $past(&cnt_bus[n])));

        assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == OFF_PRE) && (tsel == DW'(TSEL_BASE + n)))
            |=> (cnt_bus[n] == $past(wdata[CNT_W-1:0])));
    end
endmodule

bind evcnt_bank evcnt_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .CYC_W   (CYC_W),
    .DW      (DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .run     (run),
    .tsel    (tsel),
    .cnt_bus (cnt_bus),
    .cyc     (cyc),
    .ovf     (ovf)
);

// File: tb/tb_evcnt_bank.sv
`timescale 1ns/1ps
// Bench for evcnt_bank: a behavioural reference model is compared on every
// clock, and directed scenarios add checks with fixed expected values.
module tb_evcnt_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = 12'h000;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] events = '0;
    logic [15:0] ovf;

    int compared = 0;
    int mismatched = 0;
    int ovf2_seen = 0;
    int ev_mode = 0;
    logic [63:0] ev_hold = '0;
    logic [31:0] rv;
    logic [31:0] rv2;

    // reference model state
    logic [31:0] m_cnt [16];
    logic [55:0] m_cyc = '0;
    logic        m_run = 1'b0;
    logic [31:0] m_sel [4];
    logic [31:0] m_tsel = '0;
    logic [15:0] m_ovf = '0;

    always #2 clk = ~clk;   // 250 MHz

    evcnt_bank dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .events (events),
        .ovf    (ovf)
    );

    // event stimulus, applied shortly after each rising edge
    always begin
        @(posedge clk);
        #1.5;
        case (ev_mode)
            1:       events = {$urandom, $urandom};
            2:       events = ev_hold;
            default: events = '0;
        endcase
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 16; n++) m_cnt[n] = 0;
            for (int w = 0; w < 4; w++) m_sel[w] = 0;
            m_cyc = 0; m_run = 0; m_tsel = 0; m_ovf = 0;
        end else begin
            m_ovf = 0;
            for (int n = 0; n < 16; n++) begin
                logic [7:0] slot;
                slot = m_sel[n / 4][8 * (n % 4) +: 8];
                if (wr_en && addr == 12'hC0C && m_tsel == 32'(19 + n)) m_cnt[n] = wdata;
                else if (wr_en && addr == 12'hC00 && wdata[2]) m_cnt[n] = 0;
                else if (m_run && slot[7] && events[slot[5:0]]) begin
                    if (m_cnt[n] == 32'hFFFF_FFFF) m_ovf[n] = 1'b1;
                    m_cnt[n] = m_cnt[n] + 1;
                end
            end
            if (wr_en && addr == 12'hC00 && wdata[2]) m_cyc = 0;
            else if (m_run) m_cyc = m_cyc + 1;
            if (wr_en && addr == 12'hC00) begin
                if (wdata[1]) m_run = 0;
                else if (wdata[0]) m_run = 1;
            end
            if (wr_en && addr == 12'hC08) m_tsel = wdata;
            for (int w = 0; w < 4; w++)
                if (wr_en && addr == 12'(12'hC68 + 4 * w)) m_sel[w] = wdata;
        end
    end

    function automatic logic [31:0] mread(input logic [11:0] a);
        if (a == 12'hC04) return {31'd0, m_run};
        if (a == 12'hC08) return m_tsel;
        if (a == 12'hC10) return {8'd0, m_cyc[55:32]};
        if (a == 12'hC14) return m_cyc[31:0];
        for (int w = 0; w < 4; w++) if (a == 12'(12'hC68 + 4 * w)) return m_sel[w];
        for (int n = 0; n < 16; n++) if (a == 12'(12'hC78 + 4 * n)) return m_cnt[n];
        return 32'd0;
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (a >= 12'hC78 && a < 12'hCB8) return "R4";
        if (a == 12'hC10 || a == 12'hC14) return "R6";
        if (a == 12'hC04) return "R2";
        if (a >= 12'hC68 && a < 12'hC78) return "R3";
        if (a == 12'hC08) return "R8";
        return "R10";
    endfunction

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        compared++;
        if (rdata !== mread(addr)) begin
            mismatched++;
            $display("FAIL %s model read @%h: actual %h expected %h", req_of(addr), addr, rdata, mread(addr));
        end
        compared++;
        if (ovf !== m_ovf) begin
            mismatched++;
            $display("FAIL R5 model ovf: actual %h expected %h", ovf, m_ovf);
        end
        if (ovf[2]) ovf2_seen++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b0; addr = a;
        @(negedge clk); #1;
        d = rdata;
    endtask

    task automatic sweep();
        logic [31:0] tmp;
        rd(12'hC04, tmp); rd(12'hC08, tmp); rd(12'hC10, tmp); rd(12'hC14, tmp);
        for (int w = 0; w < 4; w++) rd(12'(12'hC68 + 4 * w), tmp);
        for (int n = 0; n < 16; n++) rd(12'(12'hC78 + 4 * n), tmp);
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(12'hC78, rv); check("R1 counter0 after reset", rv, 32'd0);
        rd(12'hC04, rv); check("R1 state after reset", rv, 32'd0);
        rd(12'hC68, rv); check("R1 select word after reset", rv, 32'd0);
        check("R1 ovf after reset", {16'd0, ovf}, 32'd0);
        sweep();

        // R3: slot layout; c0 evt0, c1 disabled evt2, c2 evt3, c3 evt5, c4 evt63
        wr(12'hC68, 32'h8583_0280);
        wr(12'hC6C, 32'h0000_00BF);
        wr(12'hC00, 32'h1);
        @(posedge clk); #1;
        ev_hold = 64'h8000_0000_0000_000D; ev_mode = 2;
        repeat (5) @(posedge clk);
        #1 ev_mode = 0;
        wr(12'hC00, 32'h2);
        rd(12'hC78, rv); check("R3 counter0 counts event 0", rv, 32'd5);
        rd(12'hC7C, rv); check("R3 disabled slot ignores live event", rv, 32'd0);
        rd(12'hC80, rv); check("R3 counter2 counts event 3", rv, 32'd5);
        rd(12'hC88, rv); check("R4 counter4 counts event 63", rv, 32'd5);
        rd(12'hC14, rv); rd(12'hC14, rv2); check("R6 cycle counter holds when stopped", rv2, rv);

        // R2: control semantics
        wr(12'hC00, 32'h3); rd(12'hC04, rv); check("R2 stop wins over start", rv, 32'd0);
        wr(12'hC00, 32'h0); rd(12'hC04, rv); check("R2 zero write keeps stopped", rv, 32'd0);
        wr(12'hC00, 32'h1); rd(12'hC04, rv); check("R2 start", rv, 32'd1);
        wr(12'hC00, 32'h0); rd(12'hC04, rv); check("R2 zero write keeps running", rv, 32'd1);
        wr(12'hC00, 32'h2);

        // R8 and R5: preload near wrap, then wrap
        wr(12'hC08, 32'd21); wr(12'hC0C, 32'hFFFF_FFFE); wr(12'hC08, 32'd0);
        rd(12'hC08, rv); check("R8 test-select readback", rv, 32'd0);
        rd(12'hC80, rv); check("R8 preload counter2", rv, 32'hFFFF_FFFE);
        wr(12'hC00, 32'h1);
        @(posedge clk); #1;
        ovf2_seen = 0; ev_hold = 64'h8; ev_mode = 2;
        repeat (2) @(posedge clk);
        #1 ev_mode = 0;
        wr(12'hC00, 32'h2);
        rd(12'hC80, rv); check("R5 counter2 wraps to zero", rv, 32'd0);
        check("R5 single overflow pulse", 32'(ovf2_seen), 32'd1);

        // R9: preload beats a same-edge event on counter0
        wr(12'hC08, 32'd19);
        wr(12'hC00, 32'h1);
        @(posedge clk); #1;
        ev_hold = 64'h1; ev_mode = 2;
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 12'hC0C; wdata = 32'h100;
        @(posedge clk); #1;
        addr = 12'hC00; wdata = 32'h2;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 12'hC78; ev_mode = 0;
        @(negedge clk); #1;
        check("R9 preload wins over event", rdata, 32'h101);

        // R8: out-of-range selects leave counters untouched
        wr(12'hC08, 32'd35); wr(12'hC0C, 32'd5);
        wr(12'hC08, 32'd18); wr(12'hC0C, 32'd7);
        rd(12'hC78, rv); check("R8 out-of-range preload ignored", rv, 32'h101);
        rd(12'hCB4, rv); check("R8 counter15 untouched", rv, 32'd0);

        // R7: clear keeps select words
        wr(12'hC00, 32'h4);
        rd(12'hC78, rv); check("R7 clear counter0", rv, 32'd0);
        rd(12'hC14, rv); check("R7 clear cycle low", rv, 32'd0);
        rd(12'hC10, rv); check("R7 clear cycle high", rv, 32'd0);
        rd(12'hC68, rv); check("R7 select word kept", rv, 32'h8583_0280);

        // R11: disabling slot 3 freezes counter3 only
        wr(12'hC00, 32'h1);
        @(posedge clk); #1;
        ev_hold = '1; ev_mode = 2;
        wr(12'hC68, 32'h0583_0280);
        rd(12'hC84, rv);
        rd(12'hC78, rv2);
        repeat (10) @(posedge clk);
        rd(12'hC84, wdata); check("R11 disabled counter3 frozen", wdata, rv);
        rd(12'hC78, wdata); check("R11 counter0 keeps counting", 32'(wdata > rv2), 32'd1);
        #0 ev_mode = 0;
        wr(12'hC00, 32'h2);

        // R10: unmapped and write-only offsets
        wr(12'hC20, 32'hFFFF_FFFF);
        rd(12'hC20, rv); check("R10 unmapped read zero", rv, 32'd0);
        rd(12'hC0C, rv); check("R10 preload reads zero", rv, 32'd0);
        rd(12'hC00, rv); check("R10 control reads zero", rv, 32'd0);
        sweep();

        // random traffic compared against the model every cycle
        ev_mode = 1;
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 12;
            case (r)
                0: wr(12'hC00, ($urandom % 16 == 0) ? 32'h4 : 32'h1);
                1: wr(12'hC00, ($urandom % 4 == 0) ? 32'h2 : 32'h3 & $urandom);
                2: wr(12'hC08, 32'(19 + $urandom % 18));
                3: wr(12'hC0C, 32'hFFFF_FFF0 + ($urandom % 16));
                4: wr(12'(12'hC68 + 4 * ($urandom % 4)), $urandom);
                5: wr(12'(12'hC00 + 4 * ($urandom % 64)), $urandom);
                6: sweep();
                default: rd(12'(12'hC00 + 4 * ($urandom % 64)), rv);
            endcase
        end
        ev_mode = 0;
        sweep();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule